// File: doc/BRIEF.md
# Relocatable Bus-Attached SRAM

This block is an on-chip static RAM that serves as a slave on a simple single-master internal bus. It holds an 8 KiB data array. Software can move the array's address range through two base-address registers. A small bank of control registers sits at a fixed address window and answers only supervisor data-space cycles. Every access takes a fixed two clocks. The block returns either an acknowledge or a bus-error pulse. Addresses that hit neither the register window nor the enabled array get no response, so that another slave can claim them.

After reset the array is switched off. Software first writes the base registers, then clears the disable bit in the configuration register. The base is then frozen until the array is switched off again. Bytes and 16-bit words are moved directly. A 32-bit transfer is made of two word cycles issued back to back, and it completes in four clocks.

Top module: `reloc_sram`

## Requirements
- R1: After reset, no response is pending. The configuration register reads 0x8000, with bit 15 as the array-disable flag. The test register and both base registers read 0.
- R2: A request accepted at one clock edge produces exactly one response, ack or berr, visible for one cycle after the second edge. It never produces both.
- R3: The register window starts at REG_BASE and is 16 bytes wide. The configuration register is at offset 0, the test register at 2, the high base register at 4 and the low base register at 6. The high base holds address bits 23:16 in its bits 7:0. The low base holds address bits 15:13 in its bits 15:13, and its lower bits read 0. Offsets 8 to 15 return berr.
- R4: A register access with sup=0 or dspace=0 returns berr and changes no register.
- R5: The array answers only when the disable flag is 0 and addr[23:13] equals the programmed base. Otherwise array-range cycles get neither ack nor berr.
- R6: Writes to the base registers take effect only while the disable flag is 1. While it is 0, such writes are acknowledged but ignored.
- R7: Word accesses transfer 16 bits, big-endian. A byte write with addr[0]=0 updates bits 15:8 from wdata[15:8]. A byte write with addr[0]=1 updates bits 7:0 from wdata[7:0]. A byte read returns the whole containing word.
- R8: A word access at an odd address returns berr and writes nothing.
- R9: A new request may be raised in the cycle in which the previous response is visible. Two such back-to-back word cycles complete four clocks after the first request.
- R10: The test register reads back the last value written to it and has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle per access |
| addr | input | AW | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| byte_sz | input | 1 | 1 = byte access, 0 = word access |
| sup | input | 1 | Supervisor mode |
| dspace | input | 1 | Data space (0 = program space) |
| wdata | input | 16 | Write data |
| ack | output | 1 | Access completed |
| berr | output | 1 | Access rejected |
| rdata | output | 16 | Read data, valid with ack |

## Verification
The assertions assume that the master keeps req high for exactly one cycle per access. They also assume that it raises no new request in the cycle straight after one, since the fixed-latency check looks back two cycles to the req strobe. The bench drives every access through a single task. That task pulses req for one cycle and waits out the two-clock window. The back-to-back test re-arms req only in the response cycle, so the stimulus stays within these rules.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int ARR_BYTES = 8192;
    localparam int ARR_AW    = $clog2(ARR_BYTES);
    localparam int ARR_WORDS = ARR_BYTES / 2;
    localparam int LO_BITS   = 16 - ARR_AW;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_ARRAY = 2'd1,
        HIT_REG   = 2'd2,
        HIT_ERR   = 2'd3
    } hit_e;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_TST  = 2'd1,
        SEL_BHI  = 2'd2,
        SEL_BLO  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic valid;
        hit_e kind;
    } stage_t;

    function automatic logic [15:0] lane_merge(input logic [15:0] old_w,
                                               input logic [15:0] new_w,
                                               input logic [1:0]  be);
        return {be[1] ? new_w[15:8] : old_w[15:8],
                be[0] ? new_w[7:0]  : old_w[7:0]};
    endfunction

    function automatic logic [1:0] lane_enables(input logic byte_sz, input logic a0);
        if (!byte_sz) return 2'b11;
        return a0 ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/reloc_sram_decode.sv
module reloc_sram_decode
    import sram_pkg::*;
#(
    parameter int          AW       = 24,
    parameter logic [AW-1:0] REG_BASE = 24'hFFFB40
) (
    input  logic                 req,
    input  logic [AW-1:0]        addr,
    input  logic                 byte_sz,
    input  logic                 sup,
    input  logic                 dspace,
    input  logic                 arr_dis,
    input  logic [AW-ARR_AW-1:0] base,
    output hit_e                 hit,
    output reg_sel_e             sel
);
    logic reg_win, arr_win, misaligned, priv_ok;

    always_comb begin
        reg_win    = (addr[AW-1:4] == REG_BASE[AW-1:4]);
        arr_win    = !arr_dis && (addr[AW-1:ARR_AW] == base);
        misaligned = !byte_sz && addr[0];
        priv_ok    = sup && dspace;
        sel        = reg_sel_e'(addr[2:1]);
        if (!req)
            hit = HIT_NONE;
        else if (reg_win)
            hit = (!priv_ok || addr[3] || misaligned) ? HIT_ERR : HIT_REG;
        else if (arr_win)
            hit = misaligned ? HIT_ERR : HIT_ARRAY;
        else
            hit = HIT_NONE;
    end
endmodule

// File: rtl/reloc_sram_regs.sv
module reloc_sram_regs
    import sram_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  reg_sel_e             sel,
    input  logic [1:0]           be,
    input  logic [15:0]          wdata,
    output logic [15:0]          rdata,
    output logic                 arr_dis,
    output logic [AW-ARR_AW-1:0] base
);
    localparam int HIW = AW - 16;

    logic            dis_q;
    logic [15:0]     tst_q;
    logic [HIW-1:0]  hi_q;
    logic [LO_BITS-1:0] lo_q;
    logic [15:0]     merged;

    always_comb begin
        unique case (sel)
            SEL_CFG: rdata = {dis_q, 15'b0};
            SEL_TST: rdata = tst_q;
            SEL_BHI: rdata = 16'(hi_q);
            default: rdata = {lo_q, {ARR_AW{1'b0}}};
        endcase
        merged = lane_merge(rdata, wdata, be);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q <= 1'b1;
            tst_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_CFG: dis_q <= merged[15];
                SEL_TST: tst_q <= merged;
                SEL_BHI: if (dis_q) hi_q <= merged[HIW-1:0];
                default: if (dis_q) lo_q <= merged[15:ARR_AW];
            endcase
        end
    end

    assign arr_dis = dis_q;
    assign base    = {hi_q, lo_q};
endmodule

// File: rtl/reloc_sram_array.sv
module reloc_sram_array
    import sram_pkg::*;
#(
    parameter int WORDS = ARR_WORDS
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     we,
    input  logic [1:0]               be,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [15:0]              wdata,
    output logic [15:0]              rdata
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (en) begin
            rdata <= mem[idx];
            if (we && be[1]) mem[idx][15:8] <= wdata[15:8];
            if (we && be[0]) mem[idx][7:0]  <= wdata[7:0];
        end
    end
endmodule

// File: rtl/reloc_sram.sv
module reloc_sram
    import sram_pkg::*;
#(
    parameter int            AW       = 24,
    parameter logic [AW-1:0] REG_BASE = 24'hFFFB40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          byte_sz,
    input  logic          sup,
    input  logic          dspace,
    input  logic [15:0]   wdata,
    output logic          ack,
    output logic          berr,
    output logic [15:0]   rdata
);
    localparam int IW = $clog2(ARR_WORDS);

    stage_t               stg_q;
    hit_e                 hit;
    reg_sel_e             sel;
    logic                 accept;
    logic [1:0]           be;
    logic                 arr_dis;
    logic [AW-ARR_AW-1:0] base;
    logic [15:0]          reg_rd, reg_rd_q, arr_rd;

    assign accept = req && !stg_q.valid;
    assign be     = lane_enables(byte_sz, addr[0]);

    reloc_sram_decode #(.AW(AW), .REG_BASE(REG_BASE)) dec_i (
        .req(accept), .addr(addr), .byte_sz(byte_sz), .sup(sup), .dspace(dspace),
        .arr_dis(arr_dis), .base(base), .hit(hit), .sel(sel)
    );

    reloc_sram_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst(rst), .we(hit == HIT_REG && wr), .sel(sel), .be(be),
        .wdata(wdata), .rdata(reg_rd), .arr_dis(arr_dis), .base(base)
    );

    reloc_sram_array #(.WORDS(ARR_WORDS)) arr_i (
        .clk(clk), .en(hit == HIT_ARRAY), .we(wr), .be(be),
        .idx(addr[IW:1]), .wdata(wdata), .rdata(arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q    <= '{valid: 1'b0, kind: HIT_NONE};
            reg_rd_q <= '0;
            ack      <= 1'b0;
            berr     <= 1'b0;
            rdata    <= '0;
        end else begin
            stg_q <= '{valid: (hit != HIT_NONE), kind: hit};
            if (hit == HIT_REG) reg_rd_q <= reg_rd;
            ack  <= stg_q.valid && (stg_q.kind == HIT_ARRAY || stg_q.kind == HIT_REG);
            berr <= stg_q.valid && (stg_q.kind == HIT_ERR);
            if (stg_q.valid && stg_q.kind == HIT_ARRAY)
                rdata <= arr_rd;
            else if (stg_q.valid && stg_q.kind == HIT_REG)
                rdata <= reg_rd_q;
            else
                rdata <= '0;
        end
    end
endmodule

// File: rtl/reloc_sram_chk.sv
module reloc_sram_chk #(
    parameter int BW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          req,
    input logic          ack,
    input logic          berr,
    input logic          stg_valid,
    input logic          arr_dis,
    input logic [BW-1:0] base
);
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ack && berr));

    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        (ack || berr) |-> $past(req, 2));

    a_r2_from_stage: assert property (@(posedge clk) disable iff (rst)
        (ack || berr) |-> $past(stg_valid));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (ack || berr) |=> !(ack || berr));

    a_r6_base_frozen: assert property (@(posedge clk) disable iff (rst)
        (!arr_dis && $past(!arr_dis)) |-> $stable(base));
endmodule

bind reloc_sram reloc_sram_chk #(.BW(AW - sram_pkg::ARR_AW)) chk_i (
    .clk(clk), .rst(rst), .req(req), .ack(ack), .berr(berr),
    .stg_valid(stg_q.valid), .arr_dis(arr_dis), .base(base)
);

// File: tb/reloc_sram_tb_top.sv
module reloc_sram_tb_top;
    localparam logic [23:0] RB   = 24'hFFFB40;
    localparam logic [23:0] R_CFG = RB + 24'd0;
    localparam logic [23:0] R_TST = RB + 24'd2;
    localparam logic [23:0] R_BHI = RB + 24'd4;
    localparam logic [23:0] R_BLO = RB + 24'd6;
    localparam logic [23:0] ABASE = 24'h124000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [23:0] addr = '0;
    logic        wr = 1'b0, byte_sz = 1'b0, sup = 1'b1, dspace = 1'b1;
    logic [15:0] wdata = '0;
    logic        ack, berr;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    reloc_sram #(.AW(24), .REG_BASE(RB)) dut_i (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .wr(wr), .byte_sz(byte_sz),
        .sup(sup), .dspace(dspace), .wdata(wdata), .ack(ack), .berr(berr), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // result code: 0 none, 1 ack, 2 berr, 3 both
    task automatic acc(input logic [23:0] a, input bit w, input bit bs, input bit s,
                       input bit ds, input logic [15:0] wd,
                       output int res, output logic [15:0] rd);
        @(negedge clk);
        req = 1; addr = a; wr = w; byte_sz = bs; sup = s; dspace = ds; wdata = wd;
        @(negedge clk);
        req = 0;
        if (ack || berr) begin
            n_chk++; n_bad++;
            $display("FAIL R2: early response actual %0d expected 0", {ack, berr});
        end
        @(negedge clk);
        res = {30'b0, berr, ack};
        rd  = rdata;
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 40503) ^ 23130);
    endfunction

    task automatic final_report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            final_report();
        end
    end

    initial begin
        int r;
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        chk(!ack && !berr, "R1 idle", {ack, berr}, 0);
        acc(R_CFG, 0, 0, 1, 1, 0, r, d); chk(r == 1 && d == 16'h8000, "R1 cfg", d, 16'h8000);
        acc(R_TST, 0, 0, 1, 1, 0, r, d); chk(r == 1 && d == 0, "R1 tst", d, 0);
        acc(R_BHI, 0, 0, 1, 1, 0, r, d); chk(r == 1 && d == 0, "R1 bhi", d, 0);
        acc(R_BLO, 0, 0, 1, 1, 0, r, d); chk(r == 1 && d == 0, "R1 blo", d, 0);

        // R5 disabled array: no response
        acc(24'h000000, 0, 0, 1, 1, 0, r, d); chk(r == 0, "R5 disabled", r, 0);

        // R3 R6 program base while disabled
        acc(R_BHI, 1, 0, 1, 1, 16'h0012, r, d); chk(r == 1, "R6 bhi wr", r, 1);
        acc(R_BLO, 1, 0, 1, 1, 16'h5FFF, r, d); chk(r == 1, "R6 blo wr", r, 1);
        acc(R_BLO, 0, 0, 1, 1, 0, r, d); chk(d == 16'h4000, "R3 blo mask", d, 16'h4000);
        acc(R_BHI, 0, 0, 1, 1, 0, r, d); chk(d == 16'h0012, "R3 bhi", d, 16'h0012);
        acc(ABASE, 0, 0, 1, 1, 0, r, d); chk(r == 0, "R5 still disabled", r, 0);
        acc(RB + 24'd8, 0, 0, 1, 1, 0, r, d); chk(r == 2, "R3 unmapped 8", r, 2);
        acc(RB + 24'd14, 1, 0, 1, 1, 16'hFFFF, r, d); chk(r == 2, "R3 unmapped 14", r, 2);

        // R10 test register
        acc(R_TST, 1, 0, 1, 1, 16'h1111, r, d);
        acc(R_TST, 0, 0, 1, 1, 0, r, d); chk(d == 16'h1111, "R10 tst rb", d, 16'h1111);

        // R4 privilege
        acc(R_TST, 1, 0, 0, 1, 16'hBEEF, r, d); chk(r == 2, "R4 user wr", r, 2);
        acc(R_CFG, 1, 0, 1, 0, 16'h0000, r, d); chk(r == 2, "R4 prog wr", r, 2);
        acc(R_CFG, 0, 0, 0, 1, 0, r, d); chk(r == 2, "R4 user rd", r, 2);
        acc(R_TST, 0, 0, 1, 1, 0, r, d); chk(d == 16'h1111, "R4 tst kept", d, 16'h1111);
        acc(R_CFG, 0, 0, 1, 1, 0, r, d); chk(d == 16'h8000, "R4 cfg kept", d, 16'h8000);

        // enable array
        acc(R_CFG, 1, 0, 1, 1, 16'h0000, r, d);
        acc(R_CFG, 0, 0, 1, 1, 0, r, d); chk(d == 16'h0000, "R3 cfg en", d, 0);

        // R6 base locked while enabled
        acc(R_BHI, 1, 0, 1, 1, 16'h0034, r, d); chk(r == 1, "R6 locked ack", r, 1);
        acc(R_BHI, 0, 0, 1, 1, 0, r, d); chk(d == 16'h0012, "R6 locked bhi", d, 16'h0012);
        acc(R_BLO, 1, 0, 1, 1, 16'hE000, r, d);
        acc(R_BLO, 0, 0, 1, 1, 0, r, d); chk(d == 16'h4000, "R6 locked blo", d, 16'h4000);

        // R7 full-array word sweep, in user mode (R5 array not privileged)
        for (int i = 0; i < 4096; i++) begin
            acc(ABASE + 24'(2 * i), 1, 0, 0, 1, pat(i), r, d);
            if (r != 1) chk(0, "R5 wr ack", r, 1);
        end
        for (int i = 0; i < 4096; i++) begin
            acc(ABASE + 24'(2 * i), 0, 0, 0, 1, 0, r, d);
            chk(r == 1 && d == pat(i), "R7 sweep", d, pat(i));
        end
        // R10 test register had no effect on array
        acc(R_TST, 1, 0, 1, 1, 16'hFFFF, r, d);
        acc(ABASE, 0, 0, 1, 1, 0, r, d); chk(d == pat(0), "R10 no effect", d, pat(0));

        // R5 misses on either side
        acc(ABASE - 24'd2, 0, 0, 1, 1, 0, r, d); chk(r == 0, "R5 below", r, 0);
        acc(ABASE + 24'h2000, 0, 0, 1, 1, 0, r, d); chk(r == 0, "R5 above", r, 0);

        // R7 byte lanes
        acc(ABASE + 24'd10, 1, 0, 1, 1, 16'h1234, r, d);
        acc(ABASE + 24'd10, 1, 1, 1, 1, 16'hAB00, r, d);
        acc(ABASE + 24'd10, 0, 0, 1, 1, 0, r, d); chk(d == 16'hAB34, "R7 even byte", d, 16'hAB34);
        acc(ABASE + 24'd11, 1, 1, 1, 1, 16'h00CD, r, d);
        acc(ABASE + 24'd11, 0, 1, 1, 1, 0, r, d); chk(r == 1 && d == 16'hABCD, "R7 odd byte", d, 16'hABCD);

        // R8 odd word
        acc(ABASE + 24'd11, 1, 0, 1, 1, 16'hFFFF, r, d); chk(r == 2, "R8 odd berr", r, 2);
        acc(ABASE + 24'd10, 0, 0, 1, 1, 0, r, d); chk(d == 16'hABCD, "R8 no write", d, 16'hABCD);

        // R9 back-to-back long word
        @(negedge clk);
        req = 1; addr = ABASE + 24'd20; wr = 0; byte_sz = 0; sup = 1; dspace = 1;
        @(negedge clk); req = 0;
        @(negedge clk);
        chk(ack && rdata == pat(10), "R9 first word", rdata, pat(10));
        req = 1; addr = ABASE + 24'd22;
        @(negedge clk); req = 0;
        chk(!ack && !berr, "R9 gap", {ack, berr}, 0);
        @(negedge clk);
        chk(ack && rdata == pat(11), "R9 second word", rdata, pat(11));

        // R5 disable again
        acc(R_CFG, 1, 0, 1, 1, 16'h8000, r, d);
        acc(ABASE, 0, 0, 1, 1, 0, r, d); chk(r == 0, "R5 redisabled", r, 0);

        done = 1;
        final_report();
    end
endmodule